// File: doc/BRIEF.md
# Two-User Direct-Sequence Chip Spreader

This block takes single data bits from two independent sources and turns each bit into a run of seven chips for a direct-sequence code-division link. Every source owns a three-stage pseudo-noise generator with a fixed, distinct nonzero starting state. Each accepted bit is XORed with one full period of its user's code. The two generators run apart from each other, so each user produces its own chip stream.

Coded chips enter a small per-user buffer. A shared shift enable drains every buffer at one chip per clock while it is high. While the enable is low, chips wait in the buffer and coding continues until the buffer is full. A per-user ready/valid handshake makes sure a source bit is never lost while the output is stalled. Carrier modulation and channel summing belong to the logic downstream.

Top module: `ds_two_user_spreader`

## Requirements
- R1: Each code generator is a 3-stage Fibonacci shift register. Its feedback is the XOR of stage 2 and stage 1, shifted into stage 0, which gives x^3+x+1 with a period of 7. The chip is read from stage 2. User 0 starts at state 3'b001, so its chips in output order are 0,0,1,0,1,1,1. User 1 starts at 3'b100, so its chips are 1,0,0,1,0,1,1.
- R2: Reset is asynchronous and active low. It returns both generators to their starting states and empties both buffers. The first bit accepted after reset is coded from the first chip of the code.
- R3: Each accepted bit produces exactly 7 chips. Chip k equals the bit XOR code chip k. Every bit starts at code chip 0, so XORing the output stream with the code returns the input bits in order.
- R4: A bit is taken on a clock edge where bit_valid_i and bit_ready_o are both 1. bit_ready_o is 1 when the user is idle, or when the last (seventh) chip of the current bit is written into the buffer in that cycle. Otherwise it is 0.
- R5: When shift_en_i is 1 and the user's buffer holds a chip, chip_valid_o is 1, chip_o shows the oldest chip, and that chip is removed at the clock edge. When shift_en_i is 0, chip_valid_o is 0 and no chip is removed.
- R6: Each buffer holds BUF_DEPTH chips (default 8). When the buffer is full and no chip leaves in that cycle, coding stalls and no chip is dropped or overwritten.
- R7: The users are independent. One user's idle, busy or stalled state never changes the other user's chips or handshake.
- R8: A code generator never reaches the all-zeros state.
- R9: A chip is written into the buffer in the cycle after its bit is accepted, or later if the buffer is full. It appears on chip_o from the next cycle in which shift_en_i is 1.
- R10: Directly after reset, bit_ready_o is 1 and chip_valid_o is 0 for both users.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en_i | input | 1 | Shared chip shift enable |
| bit_valid_i | input | USERS | Per-user data bit offered |
| bit_i | input | USERS | Per-user data bit value |
| bit_ready_o | output | USERS | Per-user bit acceptance ready |
| chip_o | output | USERS | Per-user coded chip |
| chip_valid_o | output | USERS | Per-user chip presented and consumed this cycle |

## Verification
The bench fills a buffer with the enable held low. A design that wraps its write pointer would then overwrite chips that have not been sent, and one that ignores the full condition would keep its ready high and drop bits. Back-to-back bits with the enable held high probe the seventh-chip handoff: a design that restarts the code late, or that takes a bit in the middle of a period, shifts every later chip against the code, and the despreading check then returns wrong bits. A reset in the middle of a stream must restart both codes from their starting states. Runs where only one user offers bits confirm that an idle neighbour leaves the other stream untouched.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int unsigned LFSR_W   = 3;
    localparam int unsigned CODE_LEN = (1 << LFSR_W) - 1;
    localparam int unsigned IDX_W    = $clog2(CODE_LEN);

    typedef struct packed {
        logic             busy;
        logic             data;
        logic [IDX_W-1:0] idx;
    } lane_state_t;
endpackage

// File: rtl/spr_lfsr.sv
module spr_lfsr #(
    parameter int unsigned    W    = 3,
    parameter logic [W-1:0]   TAPS = 3'b110,
    parameter logic [W-1:0]   SEED = 3'b001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic         chip_o,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_d, state_q;
    logic         fb;

    always_comb begin
        fb      = ^(state_q & TAPS);
        state_d = state_q;
        if (step_i) begin
            state_d = {state_q[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign chip_o  = state_q[W-1];
    assign state_o = state_q;

    // R8: the XOR feedback must never fall into the lockup state
    p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/spr_chip_fifo.sv
module spr_chip_fifo #(
    parameter int unsigned DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               din_i,
    input  logic               pop_i,
    output logic               head_o,
    output logic               empty_o,
    output logic               full_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.wp] = din_i;
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (pop_i) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign count_o = st_q.cnt;

    // R6: a write into a full buffer is only legal when a read frees a slot
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |-> pop_i);
    // R5: nothing is read from an empty buffer
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/spr_lane.sv
module spr_lane
    import spr_pkg::*;
#(
    parameter logic [LFSR_W-1:0] TAPS      = 3'b110,
    parameter logic [LFSR_W-1:0] SEED      = 3'b001,
    parameter int unsigned       BUF_DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en_i,
    input  logic bit_valid_i,
    input  logic bit_i,
    output logic bit_ready_o,
    output logic chip_o,
    output logic chip_valid_o
);
    localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1);

    lane_state_t       st_d, st_q;
    logic              code_chip;
    logic [LFSR_W-1:0] code_state;
    logic              buf_empty, buf_full, buf_head;
    logic [CNT_W-1:0]  buf_count;
    logic              pop, push, last, ready, accept, push_chip;

    spr_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (push),
        .chip_o  (code_chip),
        .state_o (code_state)
    );

    spr_chip_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (push_chip),
        .pop_i   (pop),
        .head_o  (buf_head),
        .empty_o (buf_empty),
        .full_o  (buf_full),
        .count_o (buf_count)
    );

    always_comb begin
        pop       = shift_en_i && !buf_empty;
        push      = st_q.busy && (!buf_full || pop);
        last      = (st_q.idx == IDX_W'(CODE_LEN - 1));
        ready     = !st_q.busy || (push && last);
        accept    = bit_valid_i && ready;
        push_chip = st_q.data ^ code_chip;

        st_d = st_q;
        if (push) begin
            if (last) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx  = st_q.idx + IDX_W'(1);
            end
        end
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.data = bit_i;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_ready_o  = ready;
    assign chip_o       = buf_head;
    assign chip_valid_o = pop;

    // R3: the first chip of every bit is coded from the code's starting state
    p_code_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.idx == '0) |-> code_state == SEED);
    // R4: a taken bit starts a code period on the next cycle
    p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q.busy && st_q.idx == '0));
    // R5: with the enable low the buffer never loses a chip
    p_hold_when_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> buf_count >= $past(buf_count));
endmodule

// File: rtl/ds_two_user_spreader.sv
module ds_two_user_spreader
    import spr_pkg::*;
#(
    parameter int unsigned              USERS     = 2,
    parameter int unsigned              BUF_DEPTH = 8,
    parameter logic [LFSR_W-1:0]        TAPS      = 3'b110,
    parameter logic [USERS*LFSR_W-1:0]  SEEDS     = {3'b100, 3'b001}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en_i,
    input  logic [USERS-1:0] bit_valid_i,
    input  logic [USERS-1:0] bit_i,
    output logic [USERS-1:0] bit_ready_o,
    output logic [USERS-1:0] chip_o,
    output logic [USERS-1:0] chip_valid_o
);
    for (genvar u = 0; u < USERS; u++) begin : g_user
        spr_lane #(
            .TAPS      (TAPS),
            .SEED      (SEEDS[u*LFSR_W +: LFSR_W]),
            .BUF_DEPTH (BUF_DEPTH)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .shift_en_i   (shift_en_i),
            .bit_valid_i  (bit_valid_i[u]),
            .bit_i        (bit_i[u]),
            .bit_ready_o  (bit_ready_o[u]),
            .chip_o       (chip_o[u]),
            .chip_valid_o (chip_valid_o[u])
        );
    end

    // R5: no chip leaves any user while the shared enable is low
    p_quiet_when_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |-> chip_valid_o == '0);
endmodule

// File: tb/tb_ds_two_user_spreader.sv
`timescale 1ns/1ps
module tb_ds_two_user_spreader;
    localparam int DEPTH = 8;
    localparam logic [6:0] CODE0 = 7'b0010111;
    localparam logic [6:0] CODE1 = 7'b1001011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] bv = '0, bd = '0;
    logic [1:0] br, chip, cv;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    int m_busy[2], m_data[2], m_idx[2];
    bit mq0[$], mq1[$];
    bit sent0[$], sent1[$];
    int rx_idx[2], rx_bit[2], rx_bad[2];

    always #2.5 clk = ~clk;

    ds_two_user_spreader dut (
        .clk(clk), .rst_n(rst_n), .shift_en_i(en),
        .bit_valid_i(bv), .bit_i(bd),
        .bit_ready_o(br), .chip_o(chip), .chip_valid_o(cv)
    );

    function automatic bit code_chip(int u, int k);
        return (u == 0) ? CODE0[6-k] : CODE1[6-k];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < 2; u++) begin
            m_busy[u] = 0; m_data[u] = 0; m_idx[u] = 0;
            rx_idx[u] = 0; rx_bit[u] = 0; rx_bad[u] = 0;
        end
        mq0.delete(); mq1.delete(); sent0.delete(); sent1.delete();
    endtask

    // compare one cycle, then advance the model across the coming edge
    task automatic step_model();
        for (int u = 0; u < 2; u++) begin
            int  qs   = (u == 0) ? mq0.size() : mq1.size();
            bit  pop  = en && qs > 0;
            bit  head = pop ? ((u == 0) ? mq0[0] : mq1[0]) : 1'b0;
            bit  push = (m_busy[u] != 0) && (qs < DEPTH || pop);
            bit  last = (m_idx[u] == 6);
            bit  rdy  = (m_busy[u] == 0) || (push && last);
            bit  acc  = bv[u] && rdy;
            bit  nc   = (m_data[u] != 0) ^ code_chip(u, m_idx[u]);
            check(cv[u] == pop, $sformatf("R5/R9 chip_valid user%0d", u), cv[u], pop);
            check(br[u] == rdy, $sformatf("R4/R6 ready user%0d", u), br[u], rdy);
            if (pop) begin
                check(chip[u] == head, $sformatf("R1/R3 chip user%0d", u), chip[u], head);
                if (u == 0) void'(mq0.pop_front()); else void'(mq1.pop_front());
                // despread the observed chip against the known code (R3)
                begin
                    int d = chip[u] ^ code_chip(u, rx_idx[u]);
                    if (rx_idx[u] == 0) begin rx_bit[u] = d; rx_bad[u] = 0; end
                    else if (d != rx_bit[u]) rx_bad[u] = 1;
                    if (rx_idx[u] == 6) begin
                        int sz = (u == 0) ? sent0.size() : sent1.size();
                        int ex = (sz > 0) ? ((u == 0) ? sent0.pop_front() : sent1.pop_front()) : -1;
                        check(rx_bad[u] == 0 && rx_bit[u] == ex,
                              $sformatf("R3 despread user%0d", u), rx_bit[u], ex);
                        rx_idx[u] = 0;
                    end else rx_idx[u]++;
                end
            end
            if (push) begin
                if (u == 0) mq0.push_back(nc); else mq1.push_back(nc);
                if (last) begin m_busy[u] = 0; m_idx[u] = 0; end
                else m_idx[u]++;
            end
            if (acc) begin
                m_busy[u] = 1; m_data[u] = bd[u]; m_idx[u] = 0;
                if (u == 0) sent0.push_back(bd[u]); else sent1.push_back(bd[u]);
            end
        end
    endtask

    task automatic run(int n, int en_mode, int v0_mode, int v1_mode);
        // mode: 0 = low, 1 = high, 2 = random
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            en    = (en_mode == 2) ? 1'($urandom_range(0, 1)) : 1'(en_mode);
            bv[0] = (v0_mode == 2) ? 1'($urandom_range(0, 1)) : 1'(v0_mode);
            bv[1] = (v1_mode == 2) ? 1'($urandom_range(0, 1)) : 1'(v1_mode);
            bd    = 2'($urandom_range(0, 3));
            #1;
            step_model();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; bv = '0;
        model_reset();
        #1;
        // R10 / R2: reset state
        check(br == 2'b11, "R10 ready after reset", br, 3);
        check(cv == 2'b00, "R10 chip_valid after reset", cv, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        run(2, 0, 0, 0);
        // R1: a single one bit from each user shows the inverted codes; zero shows raw code
        run(300, 1, 1, 1);
        run(400, 2, 2, 2);
        // R6: enable low, sources pushing: buffers fill, coding stalls
        run(40, 0, 1, 1);
        check(cv == 2'b00, "R6 no output while disabled", cv, 0);
        check(br == 2'b00, "R6 ready low with full buffer", br, 0);
        check(mq0.size() == DEPTH, "R6 model buffer full user0", mq0.size(), DEPTH);
        run(200, 1, 0, 0);
        // R7: only user 0 active, user 1 idle
        run(300, 2, 2, 0);
        check(br[1] == 1'b1, "R7 idle user stays ready", br[1], 1);
        run(200, 2, 0, 2);
        // R2: reset in mid-stream restarts both codes
        run(20, 1, 1, 1);
        do_reset();
        run(300, 1, 1, 1);
        run(100, 1, 0, 0);
        check(sent0.size() == 0 && sent1.size() == 0, "R3 all bits recovered",
              sent0.size() + sent1.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule